// File: doc/BRIEF.md
# Chip-Select Burst Read Planner

This block sits inside a local-bus controller. It decides how to serve a system-bus read that targets one of eight chip selects. When a request arrives, the planner picks the settings of the addressed chip select: a burst-read enable, a long-burst capability, a cache-wrap capability and a two-bit operating mode. A boot flag forces the settings of chip select 0 instead. These settings are combined with the request kind and with a flag that marks the equal-clock (1:1:1) ratio. From that the planner fixes the burst length (8 or 32 bytes) and the beat order (wrapping or linear).

It then issues the beat addresses one at a time, 8 bytes per beat, under a valid/ready handshake. A single-cycle done pulse follows the final beat. The strobe sequencer downstream consumes the beat addresses. That sequencer is not part of this block.

Top module: `csburst_planner`

## Requirements
- R1: The cycle after reset is sampled high, `busy`, `beat_valid` and `done` are all low.
- R2: A chip select whose `cs_burst_en` bit is 0 is served as one 8-byte beat at the request address with bits [2:0] cleared, with `wrap_mode` = 0.
- R3: Chip select n takes its mode from `cs_mode[2n+1:2n]`. Code 1 (flash) and code 2 (graphics) allow bursts. Codes 0 and 3 force a single 8-byte beat, whatever the capability bits say.
- R4: Request kind 1 (instruction fetch) and kind 0 (single) always give one 8-byte beat with `burst_bytes` = 8.
- R5: Kind 2 (line-aligned burst) gives 32 bytes when the chip select's `cs_long_ok` bit is 1. The four beats run in ascending order from the 32-byte line base. Otherwise it gives 8 bytes.
- R6: Kind 3 (critical-doubleword-first) gives a 32-byte burst with `wrap_mode` = 1 only when both `cs_long_ok` and `cs_wrap_ok` are 1. Otherwise it gives one 8-byte beat.
- R7: When `ratio_1to1` = 1, a flash-mode chip select gets no burst. A graphics-mode chip select is unaffected.
- R8: When `req_boot` = 1, the settings of chip select 0 are used, whatever `req_cs` holds.
- R9: A wrapping burst begins at the doubleword selected by address bits [4:3]. It then steps by 8 modulo 32 inside the same 32-byte line.
- R10: A beat advances only in a cycle with `beat_valid` and `beat_ready` both high. While `beat_ready` is low, `beat_addr` holds. `done` rises for exactly one cycle, in the cycle after the last beat is accepted.
- R11: A `start` that arrives while `busy` is high has no effect. The running burst keeps its length, order and addresses, and no extra beats follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_burst_en | input | NUM_CS | Per chip select: burst reads permitted |
| cs_long_ok | input | NUM_CS | Per chip select: 32-byte burst capable |
| cs_wrap_ok | input | NUM_CS | Per chip select: wrapping burst capable |
| cs_mode | input | 2*NUM_CS | Per chip select mode code (0 simple, 1 flash, 2 graphics, 3 other) |
| start | input | 1 | Request strobe, taken only when idle |
| req_cs | input | $clog2(NUM_CS) | Addressed chip select |
| req_boot | input | 1 | Boot chip select access, uses chip select 0 settings |
| req_kind | input | 2 | 0 single, 1 instruction fetch, 2 line burst, 3 critical-doubleword-first |
| ratio_1to1 | input | 1 | Equal-clock ratio in force |
| req_addr | input | ADDR_W | Request start address |
| beat_ready | input | 1 | Consumer accepts the current beat |
| busy | output | 1 | Planner holds a request (beats or done pending) |
| beat_valid | output | 1 | `beat_addr` carries a beat |
| beat_addr | output | ADDR_W | Current beat address, 8-byte aligned |
| burst_bytes | output | $clog2(LINE_BYTES)+1 | Planned length in bytes (8 or 32) |
| wrap_mode | output | 1 | Planned order is wrapping |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench runs each request kind against chip selects that differ in one setting at a time: the burst enable, a mode code, the long bit or the wrap bit. Each pair of runs therefore isolates one gate in the length decision. The critical-doubleword request is run at a mid-line offset, so the wrapped order cannot be mistaken for the linear one. The same request is repeated under the equal-clock flag on both a flash and a graphics chip select, which shows that the exclusion depends on the mode. A boot access with a misleading `req_cs` value, a run with toggled `beat_ready`, and a start injected mid-burst cover the override, the hold of the beat address and the rule that a start is ignored while busy.

// File: rtl/csbp_pkg.sv
package csbp_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE   = 2'd0,
    MODE_FLASH    = 2'd1,
    MODE_GRAPHICS = 2'd2,
    MODE_OTHER    = 2'd3
  } csbp_mode_e;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_IFETCH = 2'd1,
    KIND_LINE   = 2'd2,
    KIND_CRIT   = 2'd3
  } csbp_kind_e;

  typedef struct packed {
    logic       burst_en;
    logic       long_ok;
    logic       wrap_ok;
    csbp_mode_e mode;
  } csbp_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } csbp_state_e;

endpackage

// File: rtl/csbp_cfg_sel.sv
module csbp_cfg_sel
  import csbp_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0]   burst_en,
  input  logic [NUM_CS-1:0]   long_ok,
  input  logic [NUM_CS-1:0]   wrap_ok,
  input  logic [2*NUM_CS-1:0] mode_vec,
  input  logic [SEL_W-1:0]    sel,
  input  logic                boot,
  output csbp_cfg_t           cfg
);
  csbp_cfg_t per_cs [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign per_cs[g].burst_en = burst_en[g];
    assign per_cs[g].long_ok  = long_ok[g];
    assign per_cs[g].wrap_ok  = wrap_ok[g];
    assign per_cs[g].mode     = csbp_mode_e'(mode_vec[2*g +: 2]);
  end

  // The boot chip select shares the settings of chip select 0.
  always_comb begin
    if (boot) cfg = per_cs[0];
    else      cfg = per_cs[sel];
  end
endmodule

// File: rtl/csbp_decide.sv
module csbp_decide
  import csbp_pkg::*;
(
  input  csbp_cfg_t  cfg,
  input  csbp_kind_e kind,
  input  logic       ratio_1to1,
  output logic       plan_long,
  output logic       plan_wrap
);
  logic mode_ok;
  logic allowed;

  always_comb begin
    mode_ok = (cfg.mode == MODE_FLASH) || (cfg.mode == MODE_GRAPHICS);
    allowed = cfg.burst_en && mode_ok && !(ratio_1to1 && cfg.mode == MODE_FLASH);
    plan_long = 1'b0;
    plan_wrap = 1'b0;
    if (allowed) begin
      unique case (kind)
        KIND_LINE: plan_long = cfg.long_ok;
        KIND_CRIT: begin
          plan_long = cfg.long_ok && cfg.wrap_ok;
          plan_wrap = cfg.long_ok && cfg.wrap_ok;
        end
        default: plan_long = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/csbp_beat_gen.sv
module csbp_beat_gen
  import csbp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LINE_BYTES = 32,
  localparam int BEAT_SH = $clog2(BEAT_BYTES),
  localparam int LINE_SH = $clog2(LINE_BYTES),
  localparam int IDX_W   = LINE_SH - BEAT_SH,
  localparam int NBEATS  = LINE_BYTES / BEAT_BYTES,
  localparam int LEN_W   = LINE_SH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              plan_long,
  input  logic              plan_wrap,
  input  logic              beat_ready,
  output logic              busy,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LEN_W-1:0]  burst_bytes,
  output logic              wrap_mode,
  output logic              done
);
  csbp_state_e       state;
  logic [ADDR_W-1:0] line_base;
  logic [IDX_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  beat_cnt;
  logic [IDX_W-1:0]  last_cnt;
  logic [ADDR_W-1:0] start_base;
  logic [IDX_W-1:0]  crit_idx;
  logic [IDX_W-1:0]  first_idx;
  logic [IDX_W-1:0]  next_idx;

  always_comb begin
    start_base = (addr >> LINE_SH) << LINE_SH;
    crit_idx   = addr[LINE_SH-1:BEAT_SH];
    first_idx  = (plan_long && !plan_wrap) ? '0 : crit_idx;
    next_idx   = cur_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      line_base   <= '0;
      cur_idx     <= '0;
      beat_cnt    <= '0;
      last_cnt    <= '0;
      beat_addr   <= '0;
      burst_bytes <= LEN_W'(BEAT_BYTES);
      wrap_mode   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state       <= ST_ISSUE;
          line_base   <= start_base;
          cur_idx     <= first_idx;
          beat_cnt    <= '0;
          last_cnt    <= plan_long ? IDX_W'(NBEATS - 1) : '0;
          beat_addr   <= start_base | ADDR_W'({first_idx, {BEAT_SH{1'b0}}});
          burst_bytes <= plan_long ? LEN_W'(LINE_BYTES) : LEN_W'(BEAT_BYTES);
          wrap_mode   <= plan_wrap;
        end
        ST_ISSUE: if (beat_ready) begin
          if (beat_cnt == last_cnt) begin
            state <= ST_DONE;
          end else begin
            beat_cnt  <= beat_cnt + 1'b1;
            cur_idx   <= next_idx;
            beat_addr <= line_base | ADDR_W'({next_idx, {BEAT_SH{1'b0}}});
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign beat_valid = (state == ST_ISSUE);
  assign done       = (state == ST_DONE);
endmodule

// File: rtl/csburst_planner.sv
module csburst_planner
  import csbp_pkg::*;
#(
  parameter int NUM_CS     = 8,
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LINE_BYTES = 32,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int LEN_W = $clog2(LINE_BYTES) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CS-1:0]   cs_burst_en,
  input  logic [NUM_CS-1:0]   cs_long_ok,
  input  logic [NUM_CS-1:0]   cs_wrap_ok,
  input  logic [2*NUM_CS-1:0] cs_mode,
  input  logic                start,
  input  logic [SEL_W-1:0]    req_cs,
  input  logic                req_boot,
  input  logic [1:0]          req_kind,
  input  logic                ratio_1to1,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                beat_ready,
  output logic                busy,
  output logic                beat_valid,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic [LEN_W-1:0]    burst_bytes,
  output logic                wrap_mode,
  output logic                done
);
  csbp_cfg_t cfg;
  logic      plan_long;
  logic      plan_wrap;

  csbp_cfg_sel #(.NUM_CS(NUM_CS)) i_cfg_sel (
    .burst_en (cs_burst_en),
    .long_ok  (cs_long_ok),
    .wrap_ok  (cs_wrap_ok),
    .mode_vec (cs_mode),
    .sel      (req_cs),
    .boot     (req_boot),
    .cfg      (cfg)
  );

  csbp_decide i_decide (
    .cfg        (cfg),
    .kind       (csbp_kind_e'(req_kind)),
    .ratio_1to1 (ratio_1to1),
    .plan_long  (plan_long),
    .plan_wrap  (plan_wrap)
  );

  csbp_beat_gen #(
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) i_beat_gen (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .addr        (req_addr),
    .plan_long   (plan_long),
    .plan_wrap   (plan_wrap),
    .beat_ready  (beat_ready),
    .busy        (busy),
    .beat_valid  (beat_valid),
    .beat_addr   (beat_addr),
    .burst_bytes (burst_bytes),
    .wrap_mode   (wrap_mode),
    .done        (done)
  );
endmodule

// File: rtl/csbp_checker.sv
module csbp_checker #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LINE_BYTES = 32,
  localparam int BEAT_SH = $clog2(BEAT_BYTES),
  localparam int LEN_W   = $clog2(LINE_BYTES) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [LEN_W-1:0]  burst_bytes,
  input logic              wrap_mode,
  input logic              done
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !busy && !beat_valid && !done); // R1

  AST_WRAP_IS_LONG: assert property (@(posedge clk) disable iff (rst)
    busy && wrap_mode |-> burst_bytes == LEN_W'(LINE_BYTES)); // R6

  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> beat_addr[BEAT_SH-1:0] == '0); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)); // R10

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(beat_valid && beat_ready)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(burst_bytes) && $stable(wrap_mode)); // R11
endmodule

bind csburst_planner csbp_checker #(
  .ADDR_W     (ADDR_W),
  .BEAT_BYTES (BEAT_BYTES),
  .LINE_BYTES (LINE_BYTES)
) i_csbp_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .beat_valid  (beat_valid),
  .beat_ready  (beat_ready),
  .beat_addr   (beat_addr),
  .burst_bytes (burst_bytes),
  .wrap_mode   (wrap_mode),
  .done        (done)
);

// File: tb/test_csburst_planner.sv
module test_csburst_planner;
  localparam int NUM_CS = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CS-1:0] cs_burst_en, cs_long_ok, cs_wrap_ok;
  logic [2*NUM_CS-1:0] cs_mode;
  logic              start = 1'b0;
  logic [2:0]        req_cs = '0;
  logic              req_boot = 1'b0;
  logic [1:0]        req_kind = '0;
  logic              ratio_1to1 = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              beat_ready = 1'b1;
  logic              busy, beat_valid, wrap_mode, done;
  logic [ADDR_W-1:0] beat_addr;
  logic [5:0]        burst_bytes;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  csburst_planner i_csburst_planner (
    .clk(clk), .rst(rst), .cs_burst_en(cs_burst_en), .cs_long_ok(cs_long_ok),
    .cs_wrap_ok(cs_wrap_ok), .cs_mode(cs_mode), .start(start), .req_cs(req_cs),
    .req_boot(req_boot), .req_kind(req_kind), .ratio_1to1(ratio_1to1),
    .req_addr(req_addr), .beat_ready(beat_ready), .busy(busy),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .burst_bytes(burst_bytes),
    .wrap_mode(wrap_mode), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected beat address from the requirements: wrapping, linear from line base, or single.
  function automatic logic [ADDR_W-1:0] exp_beat(input logic [ADDR_W-1:0] a, input int nbeats,
                                                 input bit wrap, input int i);
    logic [ADDR_W-1:0] base;
    base = a & ~32'h1F;
    if (nbeats == 1)  return a & ~32'h7;
    if (wrap)         return base | ((a + 32'(8 * i)) & 32'h18);
    return base + 32'(8 * i);
  endfunction

  task automatic run_req(input string tag, input int cs, input bit boot, input int kind,
                         input bit ratio, input logic [ADDR_W-1:0] a, input int exp_bytes,
                         input bit exp_wrap, input bit stall, input bit inject);
    int nb = exp_bytes / 8;
    int got = 0;
    bit last_acc = 1'b0;
    bit seen_done = 1'b0;
    @(posedge clk); #1;
    req_cs = 3'(cs); req_boot = boot; req_kind = 2'(kind); ratio_1to1 = ratio;
    req_addr = a; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int cyc = 0; cyc < 24 && !seen_done; cyc++) begin
      if (cyc > 0) begin @(posedge clk); #1; end
      beat_ready = stall ? cyc[0] : 1'b1;
      if (inject && cyc == 1) begin
        start = 1'b1; req_kind = 2'd0; req_addr = a ^ 32'h40; req_cs = 3'd4;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (cyc == 0) begin
        check(tag, 64'(burst_bytes), 64'(exp_bytes), "burst_bytes");
        check(tag, 64'(wrap_mode), 64'(exp_wrap), "wrap_mode");
      end
      if (done) begin
        seen_done = 1'b1;
        check("R10", 64'(last_acc), 64'd1, "done right after last accept");
        check("R10", 64'(beat_valid), 64'd0, "no beat with done");
      end else if (beat_valid) begin
        check(tag, 64'(beat_addr), 64'(exp_beat(a, nb, exp_wrap, got)), $sformatf("beat %0d addr", got));
        last_acc = 1'b0;
        if (beat_ready) begin
          got++;
          last_acc = (got == nb);
        end
      end
    end
    start = 1'b0; beat_ready = 1'b1;
    check(tag, 64'(got), 64'(nb), "beat count");
    check("R10", 64'(seen_done), 64'd1, "done seen");
    @(negedge clk);
    check(inject ? "R11" : "R10", 64'({busy, beat_valid, done}), 64'd0, "idle after done");
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", 64'({busy, beat_valid, done}), 64'd0, "outputs after reset");
  endtask

  initial begin
    // cs0 graphics all on; cs1 flash all on; cs2 graphics long no wrap;
    // cs3 flash enable off; cs4 simple mode all on; cs5 graphics wrap no long; cs6 other mode.
    cs_burst_en = 8'b0111_0111 | 8'b0011_0000;
    cs_burst_en = 8'b0111_0111;
    cs_long_ok  = 8'b0101_1111;
    cs_wrap_ok  = 8'b0111_1011;
    cs_mode     = {2'd0, 2'd3, 2'd2, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2};
    t_reset();
    run_req("R9",  1, 1'b0, 3, 1'b0, 32'h1018, 32, 1'b1, 1'b0, 1'b0);
    run_req("R6",  1, 1'b0, 3, 1'b0, 32'h1008, 32, 1'b1, 1'b0, 1'b0);
    run_req("R5",  1, 1'b0, 2, 1'b0, 32'h2010, 32, 1'b0, 1'b1, 1'b0);
    run_req("R6",  2, 1'b0, 3, 1'b0, 32'h3014,  8, 1'b0, 1'b0, 1'b0);
    run_req("R5",  5, 1'b0, 2, 1'b0, 32'h4018,  8, 1'b0, 1'b0, 1'b0);
    run_req("R4",  1, 1'b0, 1, 1'b0, 32'h5010,  8, 1'b0, 1'b0, 1'b0);
    run_req("R4",  1, 1'b0, 0, 1'b0, 32'h5028,  8, 1'b0, 1'b0, 1'b0);
    run_req("R2",  3, 1'b0, 2, 1'b0, 32'h600C,  8, 1'b0, 1'b0, 1'b0);
    run_req("R3",  4, 1'b0, 2, 1'b0, 32'h7000,  8, 1'b0, 1'b0, 1'b0);
    run_req("R3",  6, 1'b0, 3, 1'b0, 32'h7010,  8, 1'b0, 1'b0, 1'b0);
    run_req("R7",  1, 1'b0, 3, 1'b1, 32'h8018,  8, 1'b0, 1'b0, 1'b0);
    run_req("R7",  0, 1'b0, 3, 1'b1, 32'h8018, 32, 1'b1, 1'b0, 1'b0);
    run_req("R8",  4, 1'b1, 3, 1'b0, 32'h9010, 32, 1'b1, 1'b0, 1'b0);
    run_req("R11", 1, 1'b0, 2, 1'b0, 32'hA008, 32, 1'b0, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule